// File: doc/BRIEF.md
# Linked-List Command Chain Walker

This block follows a chain of command packets stored in system RAM and streams their payload words to a downstream command consumer. The caller supplies a start address. Each packet begins with a header word that gives two things: how many payload words follow, and the byte address of the next packet. The walker fetches the header, then fetches the payload words one at a time and presents each one on a valid/ready output. It then moves on to the next packet.

The walk stops when the current address carries the end flag. While it runs, the walker adds up a cycle-cost figure for the caller. When it finishes it raises a one-cycle completion pulse and holds the cost total on an output.

A circular chain would otherwise never end. To catch this, a node counter stops the walk once a configured number of packets has been visited. In that case the walker raises a loop-error flag, which stays set until the next walk is accepted. The RAM is seen through a simple read port: one request, then one response some cycles later.

Top module: `dmaw_walker`

## Requirements
- R1: A start pulse is accepted only while the walker is idle, and only the low 24 bits of the start address are used. A start pulse while busy has no effect on the walk in progress or on its results.
- R2: A packet header holds the payload length in bits [31:24] and the next packet's 24-bit byte address in bits [23:0].
- R3: A RAM read uses the word index formed by bits [20:2] of the byte address, which wraps the address inside 2 MiB. The header is read at the packet's own index, and its payload words are read at the indices that follow it, in order.
- R4: The walk ends when the current address has bit 23 set. This includes the start address itself, in which case no RAM read is issued and the cost is 0.
- R5: A packet with length 0 forwards no payload words, and the walk continues to its successor.
- R6: The cost total is cleared when a walk is accepted. Each visited packet adds 10 to it, and a packet with nonzero length L adds a further 5 + L. The total is 32 bits wide and wraps on overflow.
- R7: While out_valid is high and out_ready is low, out_valid stays high and out_data stays stable. Every payload word is delivered exactly once and in order.
- R8: done is high for exactly one cycle when a walk ends, and busy is low in the following cycle. The cost output holds the final total while done is high. Out of reset, busy, done, out_valid, rd_req and loop_err are all low.
- R9: After LOOP_LIMIT packets have been visited, if the next address is not an end address, the walk stops with done and loop_err is set. loop_err rises together with done and stays high until the next walk is accepted. A chain of exactly LOOP_LIMIT packets ends normally with loop_err low.
- R10: At most one RAM read is outstanding at any time. No new rd_req is issued until rd_valid has returned the previous read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a walk (accepted when idle) |
| start_addr | input | 32 | Byte address of the first packet |
| busy | output | 1 | A walk is in progress |
| rd_req | output | 1 | RAM read request, one cycle |
| rd_addr | output | 19 | RAM word index |
| rd_data | input | 32 | RAM read data |
| rd_valid | input | 1 | RAM read data valid |
| out_valid | output | 1 | Payload word available |
| out_data | output | 32 | Payload word |
| out_ready | input | 1 | Consumer accepts the payload word |
| done | output | 1 | One-cycle walk-complete pulse |
| cost | output | 32 | Accumulated cost estimate |
| loop_err | output | 1 | Walk stopped by the node-count limit |

## Verification
The node-count stop and the normal end-flag stop are both decided in the same step, right after the last packet of a walk. Two cases probe this. The bench walks a linear chain of exactly LOOP_LIMIT packets, where the end flag must win and loop_err must stay low. It also walks a two-packet ring, where the limit must win. A second coincidence is a consumer stall on the final payload word of a packet: the walker must not advance to the next header until that word is taken. Sweeps of ready patterns place stalls on every word position. Each run is compared against a walk of the same RAM image that the bench computes itself.

// File: rtl/dmaw_pkg.sv
package dmaw_pkg;
  localparam int LEN_W     = 8;
  localparam int LINK_W    = 24;
  localparam int DATA_W    = LEN_W + LINK_W;
  localparam int END_BIT   = LINK_W - 1;
  localparam int NODE_COST = 10;
  localparam int PAY_COST  = 5;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CHECK,
    ST_HDR_REQ,
    ST_HDR_WAIT,
    ST_PAY_REQ,
    ST_PAY_WAIT,
    ST_PAY_OUT,
    ST_FIN
  } walk_st_e;
endpackage

// File: rtl/dmaw_rst_sync.sv
module dmaw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/dmaw_cost_acc.sv
module dmaw_cost_acc #(
  parameter int COST_W = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       add_en,
  input  logic [dmaw_pkg::LEN_W-1:0] len,
  output logic [COST_W-1:0]          total
);
  import dmaw_pkg::*;

  logic [COST_W-1:0] total_q, total_d, node_inc;
  logic              total_en;

  always_comb begin
    node_inc = COST_W'(NODE_COST);
    if (len != '0) node_inc = node_inc + COST_W'(PAY_COST) + COST_W'(len);
    total_en = clr | add_en;
    total_d  = clr ? '0 : (total_q + node_inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        total_q <= '0;
    else if (total_en) total_q <= total_d;
  end

  assign total = total_q;
endmodule

// File: rtl/dmaw_node_wd.sv
module dmaw_node_wd #(
  parameter int LOOP_LIMIT = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic inc,
  output logic at_limit
);
  localparam int CNT_W = $clog2(LOOP_LIMIT + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    at_limit = (cnt_q >= CNT_W'(LOOP_LIMIT));
    cnt_en   = clr | (inc & ~at_limit);
    cnt_d    = clr ? '0 : (cnt_q + CNT_W'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/dmaw_walker.sv
module dmaw_walker #(
  parameter int LOOP_LIMIT = 8192,
  parameter int COST_W     = 32,
  parameter int RAM_BYTE_W = 21,
  localparam int WORD_W    = RAM_BYTE_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [31:0]       start_addr,
  output logic              busy,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  input  logic [31:0]       rd_data,
  input  logic              rd_valid,
  output logic              out_valid,
  output logic [31:0]       out_data,
  input  logic              out_ready,
  output logic              done,
  output logic [COST_W-1:0] cost,
  output logic              loop_err
);
  import dmaw_pkg::*;

  logic rst_i_n;

  walk_st_e          st_q, st_d;
  logic [LINK_W-1:0] cur_q, cur_d;
  logic [LINK_W-1:0] nxt_q, nxt_d;
  logic [WORD_W-1:0] widx_q, widx_d;
  logic [LEN_W-1:0]  remain_q, remain_d;
  logic [31:0]       dout_q, dout_d;
  logic              lerr_q, lerr_d;
  logic              cost_clr, cost_add, wd_clr, wd_inc, wd_at_limit;
  logic [LEN_W-1:0]  hdr_len;
  logic [LINK_W-1:0] hdr_link;

  dmaw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  dmaw_cost_acc #(.COST_W(COST_W)) u_cost (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .clr    (cost_clr),
    .add_en (cost_add),
    .len    (hdr_len),
    .total  (cost)
  );

  dmaw_node_wd #(.LOOP_LIMIT(LOOP_LIMIT)) u_wd (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .clr      (wd_clr),
    .inc      (wd_inc),
    .at_limit (wd_at_limit)
  );

  assign hdr_len  = rd_data[DATA_W-1:LINK_W];
  assign hdr_link = rd_data[LINK_W-1:0];

  logic unused_start_hi;
  logic unused_cur_bits;
  assign unused_start_hi = ^start_addr[31:LINK_W];
  assign unused_cur_bits = ^{cur_q[LINK_W-2:RAM_BYTE_W], cur_q[1:0]};

  // next-state process
  always_comb begin
    st_d     = st_q;
    cur_d    = cur_q;
    nxt_d    = nxt_q;
    widx_d   = widx_q;
    remain_d = remain_q;
    dout_d   = dout_q;
    lerr_d   = lerr_q;
    cost_clr = 1'b0;
    cost_add = 1'b0;
    wd_clr   = 1'b0;
    wd_inc   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          cur_d    = start_addr[LINK_W-1:0];
          lerr_d   = 1'b0;
          cost_clr = 1'b1;
          wd_clr   = 1'b1;
          st_d     = ST_CHECK;
        end
      end
      ST_CHECK: begin
        if (cur_q[END_BIT]) begin
          st_d = ST_FIN;
        end else if (wd_at_limit) begin
          lerr_d = 1'b1;
          st_d   = ST_FIN;
        end else begin
          st_d = ST_HDR_REQ;
        end
      end
      ST_HDR_REQ: st_d = ST_HDR_WAIT;
      ST_HDR_WAIT: begin
        if (rd_valid) begin
          cost_add = 1'b1;
          wd_inc   = 1'b1;
          remain_d = hdr_len;
          nxt_d    = hdr_link;
          widx_d   = cur_q[RAM_BYTE_W-1:2] + WORD_W'(1);
          if (hdr_len == '0) begin
            cur_d = hdr_link;
            st_d  = ST_CHECK;
          end else begin
            st_d = ST_PAY_REQ;
          end
        end
      end
      ST_PAY_REQ: st_d = ST_PAY_WAIT;
      ST_PAY_WAIT: begin
        if (rd_valid) begin
          dout_d = rd_data;
          st_d   = ST_PAY_OUT;
        end
      end
      ST_PAY_OUT: begin
        if (out_ready) begin
          remain_d = remain_q - LEN_W'(1);
          widx_d   = widx_q + WORD_W'(1);
          if (remain_q == LEN_W'(1)) begin
            cur_d = nxt_q;
            st_d  = ST_CHECK;
          end else begin
            st_d = ST_PAY_REQ;
          end
        end
      end
      ST_FIN: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q     <= ST_IDLE;
      cur_q    <= '0;
      nxt_q    <= '0;
      widx_q   <= '0;
      remain_q <= '0;
      dout_q   <= '0;
      lerr_q   <= 1'b0;
    end else begin
      st_q     <= st_d;
      cur_q    <= cur_d;
      nxt_q    <= nxt_d;
      widx_q   <= widx_d;
      remain_q <= remain_d;
      lerr_q   <= lerr_d;
      if (st_q == ST_PAY_WAIT) dout_q <= dout_d;
    end
  end

  assign busy      = (st_q != ST_IDLE);
  assign done      = (st_q == ST_FIN);
  assign rd_req    = (st_q == ST_HDR_REQ) || (st_q == ST_PAY_REQ);
  assign rd_addr   = (st_q == ST_HDR_REQ) ? cur_q[RAM_BYTE_W-1:2] : widx_q;
  assign out_valid = (st_q == ST_PAY_OUT);
  assign out_data  = dout_q;
  assign loop_err  = lerr_q;
endmodule

// File: rtl/dmaw_walker_chk.sv
module dmaw_walker_chk #(
  parameter int WORD_W = 19,
  parameter int COST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [31:0]       start_addr,
  input logic              busy,
  input logic              rd_req,
  input logic [WORD_W-1:0] rd_addr,
  input logic              rd_valid,
  input logic              out_valid,
  input logic [31:0]       out_data,
  input logic              out_ready,
  input logic              done,
  input logic [COST_W-1:0] cost,
  input logic              loop_err
);
  logic pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        pend_q <= 1'b0;
    else if (rd_req)   pend_q <= 1'b1;
    else if (rd_valid) pend_q <= 1'b0;
  end

  // R10
  one_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !rd_req);

  // R7
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));

  // R8
  cost_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> $stable(cost));

  // R9
  lerr_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(loop_err) |-> done);

  // R4
  end_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && start_addr[23]) |=> !rd_req);

  // R1
  out_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid || rd_req) |-> busy);

  logic unused_chk;
  assign unused_chk = ^rd_addr;
endmodule

bind dmaw_walker dmaw_walker_chk #(.WORD_W(WORD_W), .COST_W(COST_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .start_addr (start_addr),
  .busy       (busy),
  .rd_req     (rd_req),
  .rd_addr    (rd_addr),
  .rd_valid   (rd_valid),
  .out_valid  (out_valid),
  .out_data   (out_data),
  .out_ready  (out_ready),
  .done       (done),
  .cost       (cost),
  .loop_err   (loop_err)
);

// File: tb/dmaw_walker_test.sv
module dmaw_walker_test;
  localparam int LIM = 8;
  localparam int WW  = 19;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [31:0]   start_addr = '0;
  logic          busy, rd_req, rd_valid, out_valid, out_ready, done, loop_err;
  logic [WW-1:0] rd_addr;
  logic [31:0]   rd_data, out_data, cost;

  dmaw_walker #(.LOOP_LIMIT(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .rd_valid(rd_valid), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .done(done), .cost(cost), .loop_err(loop_err)
  );

  always #5 clk = ~clk;

  logic [31:0] mem [0:255];
  int checks = 0;
  int errors = 0;

  function automatic logic [31:0] rdw(input logic [WW-1:0] idx);
    if (idx < 256) return mem[idx[7:0]];
    return 32'hBAD0_0000 ^ 32'(idx);
  endfunction

  // RAM model, fixed latency of three cycles
  logic          v1 = 0, v2 = 0, v3 = 0;
  logic [WW-1:0] a1 = '0, a2 = '0, a3 = '0;
  always @(posedge clk) begin
    v1 <= rd_req; a1 <= rd_addr;
    v2 <= v1;     a2 <= a1;
    v3 <= v2;     a3 <= a2;
  end
  assign rd_valid = v3;
  assign rd_data  = rdw(a3);

  // ready pattern driver
  int        rmode = 0;
  int        cyc = 0;
  logic [15:0] lfsr = 16'hACE1;
  always @(negedge clk) begin
    cyc++;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    case (rmode)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0];
      2: out_ready = lfsr[0];
      default: out_ready = (cyc % 4 == 0);
    endcase
  end

  // monitor
  logic [31:0] got [0:511];
  int ngot = 0, ndone = 0, nreq = 0;
  logic [31:0] got_cost = '0;
  logic        got_lerr = 1'b0;
  always @(posedge clk) begin
    if (out_valid && out_ready && ngot < 512) begin got[ngot] = out_data; ngot++; end
    if (done) begin ndone++; got_cost = cost; got_lerr = loop_err; end
    if (rd_req) nreq++;
  end

  // expected walk
  logic [31:0] exp_w [0:511];
  int          exp_n, exp_reads;
  logic [31:0] exp_cost;
  logic        exp_lerr;

  task automatic model(input logic [31:0] sa);
    logic [23:0] a;
    logic [31:0] h;
    int nodes;
    a = sa[23:0]; nodes = 0; exp_n = 0; exp_reads = 0; exp_cost = 0; exp_lerr = 0;
    while (1) begin
      if (a[23]) break;
      if (nodes == LIM) begin exp_lerr = 1; break; end
      h = rdw(a[20:2]);
      exp_reads++;
      exp_cost += 10;
      if (h[31:24] != 0) exp_cost += 5 + 32'(h[31:24]);
      for (int k = 1; k <= int'(h[31:24]); k++) begin
        if (exp_n < 512) exp_w[exp_n] = rdw(a[20:2] + WW'(k));
        exp_n++; exp_reads++;
      end
      a = h[23:0];
      nodes++;
    end
  endtask

  task automatic chk(input logic ok, input string req, input string tag,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, tag, act, expv);
    end
  endtask

  task automatic run_walk(input logic [31:0] sa, input int mode,
                          input int inject, input string tag);
    int t;
    bit bad;
    model(sa);
    rmode = mode;
    @(negedge clk);
    ngot = 0; ndone = 0; nreq = 0;
    start = 1'b1; start_addr = sa;
    @(negedge clk);
    start = 1'b0;
    t = 0;
    while (ndone == 0 && t < 3000) begin
      @(negedge clk);
      t++;
      if (t == inject) begin
        start = 1'b1; start_addr = 32'h0080_0000;
        @(negedge clk);
        start = 1'b0;
      end
    end
    @(negedge clk);
    @(negedge clk);
    chk(ndone == 1, "R8", tag, 32'(ndone), 1);
    chk(!busy, "R8", tag, 32'(busy), 0);
    chk(ngot == exp_n, "R7", tag, 32'(ngot), 32'(exp_n));
    bad = 0;
    for (int i = 0; i < ngot && i < exp_n && i < 512; i++) begin
      if (!bad && got[i] !== exp_w[i]) begin
        chk(0, "R3", tag, got[i], exp_w[i]);
        bad = 1;
      end
    end
    if (!bad) chk(1, "R3", tag, 0, 0);
    chk(got_cost == exp_cost, "R6", tag, got_cost, exp_cost);
    chk(got_lerr == exp_lerr, "R9", tag, 32'(got_lerr), 32'(exp_lerr));
    chk(nreq == exp_reads, "R10", tag, 32'(nreq), 32'(exp_reads));
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'hC000_0000 | 32'(i);
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(!busy && !done && !out_valid && !rd_req && !loop_err, "R8", "reset",
        {27'd0, busy, done, out_valid, rd_req, loop_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R2 single packet: length 3, end marker link
    mem[8'h10] = {8'd3, 24'hFFFFFF};
    run_walk(32'h0000_0040, 0, 0, "R2 single");

    // R1 upper bits masked; R5 empty packet; R3 21-bit wrap of link
    mem[8'h40] = {8'd0, 24'h200080};
    mem[8'h20] = {8'd2, 24'h800000};
    run_walk(32'hAB00_0100, 1, 0, "R1 R5 masked chain");

    // R4 start address already an end address
    run_walk(32'h0080_0040, 0, 0, "R4 end start");
    chk(nreq == 0, "R4", "no read", 32'(nreq), 0);
    chk(got_cost == 0, "R4", "zero cost", got_cost, 0);

    // R1 start while busy is ignored
    run_walk(32'h0000_0040, 3, 6, "R1 busy start");

    // R7 R6 sweep of two-packet chains over lengths and ready patterns
    for (int la = 0; la < 6; la++)
      for (int lb = 0; lb < 6; lb++)
        for (int m = 0; m < 4; m++) begin
          mem[8'h80] = {8'(la), 24'h000300};
          mem[8'hC0] = {8'(lb), 24'hFFFFFF};
          run_walk(32'h0000_0200, m, 0, "R7 sweep");
        end

    // R9 circular chain stops at the limit
    mem[8'h00] = {8'd1, 24'h000010};
    mem[8'h04] = {8'd2, 24'h000000};
    run_walk(32'h0000_0000, 2, 0, "R9 ring");
    repeat (5) @(negedge clk);
    chk(loop_err == 1'b1, "R9", "sticky", 32'(loop_err), 1);

    // R9 chain of exactly LIM packets ends normally
    for (int i = 0; i < LIM; i++)
      mem[8'h50 + 2*i] = {8'd1, (i == LIM-1) ? 24'hFFFFFF : 24'(32'h140 + 8*(i+1))};
    run_walk(32'h0000_0140, 1, 0, "R9 exact limit");
    chk(loop_err == 1'b0, "R9", "cleared", 32'(loop_err), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule